// File: doc/BRIEF.md
# Serial Command Frame Decoder

This block sits behind a byte-wide serial receiver and turns the incoming byte stream into control actions for a logic-capture engine. Each byte arrives as a one-cycle `rx_valid` qualifier with `rx_byte`. A byte seen while no frame is open is an opcode. Opcodes with bit 7 clear are single-byte commands. Opcodes with bit 7 set open a five-byte frame: the opcode and then a 32-bit argument sent least-significant byte first.

Completed single-byte commands raise a one-cycle reset or arm pulse. Completed long frames raise a one-cycle write strobe carrying the opcode and its value, and they load the configuration register that the opcode addresses. The registers are the per-stage trigger mask, value and configuration, the sample-clock divider, the read and delay counts, and the capture flags.

The host brings the decoder back into step by sending the reset opcode five times. If the argument bytes of a frame stop arriving for too long, the frame is dropped.

Top module: `cmd_frame_decoder`

## Requirements
- R1: A byte accepted with no frame open is an opcode. Bit 7 = 0 makes it a complete one-byte command. Bit 7 = 1 opens a frame that completes only on the fourth argument byte after it.
- R2: On the fourth argument byte, `wr_strobe` is high for exactly the next cycle. In that cycle `wr_op` holds the opcode and `wr_value` holds the argument, with the first argument byte in bits 7:0 and the last in bits 31:24. This holds for every long opcode, including unknown ones.
- R3: Opcode 0x00 raises `reset_pulse` and opcode 0x01 raises `arm_pulse`, each for the cycle after the byte. Any other short opcode raises no pulse and changes no register. At most one of `reset_pulse`, `arm_pulse` and `wr_strobe` is high in any cycle.
- R4: Five back-to-back 0x00 bytes, starting from any point of any frame, leave the decoder with no frame open, and the byte after them is taken as an opcode. Argument bytes are consumed literally, so a frame that was open completes with zero bytes in its remaining positions.
- R5: For stage s < STAGES, opcode 0xC0+4s loads the stage's mask, 0xC1+4s loads its value and 0xC2+4s loads its configuration. Each of these is 32 bits wide, and stage s occupies bits 32s+31:32s of `trig_mask`, `trig_value` and `trig_cfg`. Opcode 0xC3+4s and every other unassigned long opcode change no register.
- R6: Opcode 0x80 loads `divider` with bits 23:0 of the argument. The upper byte is dropped.
- R7: Opcode 0x81 is the combined capture-size command. `read_count` takes bits 15:0 of the argument, zero-extended. `delay_count` takes bits 31:16, zero-extended.
- R8: Opcode 0x83 loads all 32 bits of `read_count`, and opcode 0x84 loads all 32 bits of `delay_count`.
- R9: Opcode 0x82 loads all 32 bits of `flags`. No register changes in a cycle without `wr_strobe`.
- R10: `trig_start[s]` equals bit 27 (byte 3, bit 3) of stage s's configuration, which marks the stage that fires the capture. Bits 23:16 of the configuration carry the stage level.
- R11: While a frame is open, a run of TIMEOUT consecutive cycles with no byte drops the frame, and the next byte is taken as an opcode. A run of TIMEOUT-1 cycles does not drop it.
- R12: After reset all registers are zero and no pulse or strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte qualifier, one cycle per byte |
| rx_byte | input | 8 | Received byte |
| reset_pulse | output | 1 | One-cycle pulse on a reset command |
| arm_pulse | output | 1 | One-cycle pulse on an arm command |
| wr_strobe | output | 1 | One-cycle pulse on each completed long frame |
| wr_op | output | 8 | Opcode of the last completed long frame |
| wr_value | output | 32 | Argument of the last completed long frame |
| trig_mask | output | 32*STAGES | Per-stage trigger masks |
| trig_value | output | 32*STAGES | Per-stage trigger values |
| trig_cfg | output | 32*STAGES | Per-stage trigger configuration |
| trig_start | output | STAGES | Per-stage fire bit taken from the configuration |
| divider | output | 24 | Sample-clock divider |
| read_count | output | 32 | Capture read count |
| delay_count | output | 32 | Capture delay count |
| flags | output | 32 | Capture flag register |

## Verification
A frame counter that is out of step shows at the ports as soon as the next command completes. `wr_strobe` then arrives a byte early or late, the wrong register loads, or an argument byte raises a reset or arm pulse. All of these are visible in the cycle after the offending byte.

Errors in byte order or field slicing show in the loaded register one cycle after the last argument byte. A wrong inter-byte timeout shows as a frame that survives or dies across a gap of exactly TIMEOUT-1 or TIMEOUT idle cycles, visible in the cycle after the following byte.

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder #(
  parameter int STAGES  = 4,
  parameter int TIMEOUT = 4096
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_byte,
  output logic                  reset_pulse,
  output logic                  arm_pulse,
  output logic                  wr_strobe,
  output logic [7:0]            wr_op,
  output logic [31:0]           wr_value,
  output logic [32*STAGES-1:0]  trig_mask,
  output logic [32*STAGES-1:0]  trig_value,
  output logic [32*STAGES-1:0]  trig_cfg,
  output logic [STAGES-1:0]     trig_start,
  output logic [23:0]           divider,
  output logic [31:0]           read_count,
  output logic [31:0]           delay_count,
  output logic [31:0]           flags
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [7:0] OP_DIV = 8'h80, OP_SIZE = 8'h81, OP_FLAGS = 8'h82,
                         OP_READ = 8'h83, OP_DELAY = 8'h84, OP_STAGE = 8'hC0;

  logic [2:0]    idx;
  logic [7:0]    op;
  logic [31:0]   sh;
  logic [TW-1:0] gap;

  wire        busy = idx != 3'd0;
  wire        last = rx_valid && idx == 3'd4;
  wire [31:0] full = {rx_byte, sh[31:8]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0; op <= '0; sh <= '0; gap <= '0;
      reset_pulse <= 1'b0; arm_pulse <= 1'b0; wr_strobe <= 1'b0;
      wr_op <= '0; wr_value <= '0;
    end else begin
      reset_pulse <= 1'b0;
      arm_pulse   <= 1'b0;
      wr_strobe   <= 1'b0;
      if (rx_valid) begin
        gap <= '0;
        if (!busy) begin
          if (rx_byte[7]) begin
            op  <= rx_byte;
            idx <= 3'd1;
          end else begin
            reset_pulse <= rx_byte == 8'h00;
            arm_pulse   <= rx_byte == 8'h01;
          end
        end else begin
          sh <= full;
          if (idx == 3'd4) begin
            idx       <= '0;
            wr_strobe <= 1'b1;
            wr_op     <= op;
            wr_value  <= full;
          end else begin
            idx <= idx + 3'd1;
          end
        end
      end else if (busy) begin
        if (gap == TW'(TIMEOUT - 1)) begin
          idx <= '0;
          gap <= '0;
        end else begin
          gap <= gap + TW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_mask <= '0; trig_value <= '0; trig_cfg <= '0;
      divider <= '0; read_count <= '0; delay_count <= '0; flags <= '0;
    end else if (last) begin
      case (op)
        OP_DIV:   divider <= full[23:0];
        OP_SIZE:  begin
                    read_count  <= {16'h0, full[15:0]};
                    delay_count <= {16'h0, full[31:16]};
                  end
        OP_FLAGS: flags <= full;
        OP_READ:  read_count <= full;
        OP_DELAY: delay_count <= full;
        default: ;
      endcase
      for (int s = 0; s < STAGES; s++) begin
        if (op == OP_STAGE + 8'(4 * s))     trig_mask[32*s +: 32]  <= full;
        if (op == OP_STAGE + 8'(4 * s + 1)) trig_value[32*s +: 32] <= full;
        if (op == OP_STAGE + 8'(4 * s + 2)) trig_cfg[32*s +: 32]   <= full;
      end
    end
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_start
    assign trig_start[g] = trig_cfg[32*g + 27];
  end

  assert_one_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reset_pulse, arm_pulse, wr_strobe}));

  assert_reset_from_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse |-> $past(rx_valid && rx_byte == 8'h00));

  assert_strobe_after_arg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> $past(rx_valid) && $past(busy));

  assert_resync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_byte == 8'h00) &&
    $past(rx_valid && rx_byte == 8'h00, 1) && $past(rx_valid && rx_byte == 8'h00, 2) &&
    $past(rx_valid && rx_byte == 8'h00, 3) && $past(rx_valid && rx_byte == 8'h00, 4)
    |=> !busy);

  assert_divider_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |-> $stable(divider));

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |-> $stable(flags) && $stable(read_count) && $stable(trig_cfg));
endmodule

// File: tb/test_cmd_frame_decoder.sv
module test_cmd_frame_decoder;
  localparam int STAGES = 4;
  localparam int TIMEOUT = 16;

  logic clk = 1'b0, rst_n = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic reset_pulse, arm_pulse, wr_strobe;
  logic [7:0] wr_op;
  logic [31:0] wr_value, read_count, delay_count, flags;
  logic [32*STAGES-1:0] trig_mask, trig_value, trig_cfg;
  logic [STAGES-1:0] trig_start;
  logic [23:0] divider;

  always #2 clk = ~clk;

  cmd_frame_decoder #(.STAGES(STAGES), .TIMEOUT(TIMEOUT)) i_cmd_frame_decoder (
    .clk, .rst_n, .rx_valid, .rx_byte, .reset_pulse, .arm_pulse, .wr_strobe,
    .wr_op, .wr_value, .trig_mask, .trig_value, .trig_cfg, .trig_start,
    .divider, .read_count, .delay_count, .flags);

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [31:0] e_mask [STAGES], e_val [STAGES], e_cfg [STAGES];
  logic [31:0] e_div, e_read, e_delay, e_flags;

  localparam logic [39:0] VEC [12] = '{
    {8'hC4, 32'hDEAD_BEEF}, {8'hC9, 32'h1357_9BDF}, {8'hCE, 32'h0803_0000},
    {8'hC2, 32'h0001_0000}, {8'h80, 32'hABCD_EF12}, {8'h81, 32'h1234_5678},
    {8'h82, 32'h0000_003C}, {8'h83, 32'h0004_0000}, {8'h84, 32'h8000_0001},
    {8'hC3, 32'hFFFF_FFFF}, {8'h90, 32'h5555_AAAA}, {8'hC0, 32'h0000_00FF}};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic model(logic [7:0] op, logic [31:0] v);
    for (int s = 0; s < STAGES; s++) begin
      if (op == 8'hC0 + 8'(4*s)) e_mask[s] = v;
      if (op == 8'hC1 + 8'(4*s)) e_val[s]  = v;
      if (op == 8'hC2 + 8'(4*s)) e_cfg[s]  = v;
    end
    case (op)
      8'h80: e_div = {8'h0, v[23:0]};
      8'h81: begin e_read = {16'h0, v[15:0]}; e_delay = {16'h0, v[31:16]}; end
      8'h82: e_flags = v;
      8'h83: e_read = v;
      8'h84: e_delay = v;
      default: ;
    endcase
  endtask

  task automatic check_regs(string tag);
    for (int s = 0; s < STAGES; s++) begin
      check({tag, " R5 mask"}, trig_mask[32*s +: 32], e_mask[s]);
      check({tag, " R5 value"}, trig_value[32*s +: 32], e_val[s]);
      check({tag, " R5 cfg"}, trig_cfg[32*s +: 32], e_cfg[s]);
      check({tag, " R10 start"}, 32'(trig_start[s]), 32'(e_cfg[s][27]));
    end
    check({tag, " R6 divider"}, {8'h0, divider}, e_div);
    check({tag, " R7/R8 read"}, read_count, e_read);
    check({tag, " R7/R8 delay"}, delay_count, e_delay);
    check({tag, " R9 flags"}, flags, e_flags);
  endtask

  task automatic send_long(logic [7:0] op, logic [31:0] v, string tag);
    send_byte(op);
    for (int k = 0; k < 4; k++) begin
      send_byte(v[8*k +: 8]);
      if (k < 3) check({tag, " R1 no early strobe"}, 32'(wr_strobe), 32'd0);
    end
    model(op, v);
    check({tag, " R2 strobe"}, 32'(wr_strobe), 32'd1);
    check({tag, " R2 op"}, 32'(wr_op), 32'(op));
    check({tag, " R2 value"}, wr_value, v);
    @(negedge clk);
    check({tag, " R2 strobe one cycle"}, 32'(wr_strobe), 32'd0);
    check_regs(tag);
  endtask

  initial begin
    for (int s = 0; s < STAGES; s++) begin e_mask[s] = 0; e_val[s] = 0; e_cfg[s] = 0; end
    e_div = 0; e_read = 0; e_delay = 0; e_flags = 0;
    repeat (3) @(negedge clk);
    check("R12 reset pulses", {29'h0, reset_pulse, arm_pulse, wr_strobe}, 32'd0);
    check_regs("R12 reset");
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) send_long(VEC[i][39:32], VEC[i][31:0], "vector");

    send_byte(8'h00);
    check("R3 reset pulse", {30'h0, reset_pulse, arm_pulse}, 32'd2);
    @(negedge clk);
    check("R3 reset pulse one cycle", 32'(reset_pulse), 32'd0);
    send_byte(8'h01);
    check("R3 arm pulse", {30'h0, reset_pulse, arm_pulse}, 32'd1);
    send_byte(8'h05);
    check("R3 other short ignored", {29'h0, reset_pulse, arm_pulse, wr_strobe}, 32'd0);
    check_regs("R3 other short");

    send_byte(8'h80); send_byte(8'h11); send_byte(8'h22);
    for (int k = 0; k < 5; k++) send_byte(8'h00);
    model(8'h80, 32'h0000_2211);
    check_regs("R4 resync");
    send_byte(8'h01);
    check("R4 opcode after resync", 32'(arm_pulse), 32'd1);

    send_byte(8'h82); send_byte(8'hA1); send_byte(8'hB2);
    repeat (TIMEOUT - 1) @(negedge clk);
    send_byte(8'hC3); send_byte(8'hD4);
    check("R11 gap below limit keeps frame", 32'(wr_strobe), 32'd1);
    model(8'h82, 32'hD4C3_B2A1);
    check_regs("R11 kept");

    send_byte(8'h82); send_byte(8'h77); send_byte(8'h66);
    repeat (TIMEOUT) @(negedge clk);
    send_byte(8'h01);
    check("R11 timeout drops frame", 32'(arm_pulse), 32'd1);
    send_byte(8'h02); send_byte(8'h03);
    check("R11 no strobe after drop", 32'(wr_strobe), 32'd0);
    check_regs("R11 dropped");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule